// File: doc/BRIEF.md
# Time-Triggered Time Mark Matcher

This block keeps a time mark and a cycle code for a time-triggered CAN controller. It raises a single-clock event when the network time base reaches that mark in a basic cycle that the code selects. A host-side register port writes the 16-bit mark and the 7-bit cycle code. A companion configuration register holds a 2-bit time-mark control field.

The written values reach the CAN clock domain through a toggle request/acknowledge handshake. A lock flag keeps the mark register read-only until the CAN domain has taken the values. The CAN domain then compares the running time base with the captured mark. It also checks the 6-bit basic-cycle count against the captured cycle code.

The cycle code works like this. The position of its highest set bit (k = 1..6) selects a repetition period of 2^k cycles. The k bits below that bit give the residue that the cycle count must have. A code with no set bit above bit 0 matches in every cycle.

Top module: `ttmark_matcher`

## Requirements
- R1: After reset, rd_data is 0 and match is 0.
- R2: rd_data carries the mark in bits 15:0, the cycle code in bits 22:16 and the lock flag in bit 31. Bits 30:23 always read as zero.
- R3: A mark write (wr_en with wr_sel=0) updates mark and code from wr_data[15:0] and wr_data[22:16] when the lock flag is 0. When the lock flag is 1, the write is ignored.
- R4: A configuration write (wr_en with wr_sel=1, control field in wr_data[1:0]) always sets the lock flag, seen on rd_data one host clock later.
- R5: An accepted mark write sets the lock flag only when the stored control field is not 00. Otherwise the lock flag stays 0.
- R6: Once set, the lock flag clears within 16 host clocks, after the CAN domain has captured the mark and code.
- R7: match is high for one CAN clock. It is high in the cycle after a sample where the time base differs from its previous sample, equals the captured mark, and meets the cycle condition.
- R8: No further match pulse occurs while the time base holds the matched value.
- R9: A captured code whose bits 6:1 are all zero meets the cycle condition for every cycle count.
- R10: A captured code whose highest set bit is bit k (1..6) meets the cycle condition only when cycle count mod 2^k equals code bits k-1:0.
- R11: Matching uses only the mark and code last captured in the CAN domain. A mark write that started no transfer has no effect on match until a later transfer carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host clock |
| rst_h_n | input | 1 | Host-domain asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mark register, 1 the configuration register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Mark register readback with lock flag |
| clk_c | input | 1 | CAN clock |
| rst_c_n | input | 1 | CAN-domain asynchronous reset, active low |
| time_base | input | 16 | Running network time base |
| cycle_cnt | input | 6 | Current basic-cycle count |
| match | output | 1 | One-clock time mark event |

## Verification
The handshake can fail in two ways. A stuck lock shows at once as bit 31 of rd_data staying high past its 16-clock bound. A lost or early capture shows as a missing pulse, or a pulse at the old mark, on the first time-base step after the transfer.

Decoder faults appear at match one CAN clock after the offending sample. Those faults are a wrong leading-one position or residue width, and an edge detector that fires on a held value. Mixed random codes and cycle counts reach most residues within a few dozen steps.

// File: rtl/ttmark_matcher.sv
module ttmark_matcher (
  input  logic        clk_h,
  input  logic        rst_h_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        clk_c,
  input  logic        rst_c_n,
  input  logic [15:0] time_base,
  input  logic [5:0]  cycle_cnt,
  output logic        match
);
  localparam int TM_W   = 16;
  localparam int CYC_W  = 6;
  localparam int CODE_W = CYC_W + 1;

  logic [TM_W-1:0]   mark_q;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        tmc_q;
  logic              lock_q, again_q, req_t;
  logic              ak1, ak2;

  wire cfg_wr   = wr_en && wr_sel;
  wire mark_wr  = wr_en && !wr_sel;
  wire done     = lock_q && (ak2 == req_t);
  wire unused_hi = ^wr_data[31:23];

  assign rd_data = {lock_q, 8'b0, code_q, mark_q};

  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) begin
      mark_q  <= '0;
      code_q  <= '0;
      tmc_q   <= '0;
      lock_q  <= 1'b0;
      again_q <= 1'b0;
      req_t   <= 1'b0;
    end else if (cfg_wr) begin
      tmc_q <= wr_data[1:0];
      if (!lock_q || done) begin
        req_t   <= ~req_t;
        lock_q  <= 1'b1;
        again_q <= 1'b0;
      end else begin
        again_q <= 1'b1;
      end
    end else if (mark_wr && !lock_q) begin
      mark_q <= wr_data[TM_W-1:0];
      code_q <= wr_data[16 +: CODE_W];
      if (tmc_q != 2'b00) begin
        req_t  <= ~req_t;
        lock_q <= 1'b1;
      end
    end else if (done) begin
      if (again_q) begin
        req_t   <= ~req_t;
        again_q <= 1'b0;
      end else begin
        lock_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) begin
      ak1 <= 1'b0;
      ak2 <= 1'b0;
    end else begin
      ak1 <= rq3;
      ak2 <= ak1;
    end
  end

  logic              rq1, rq2, rq3;
  logic [TM_W-1:0]   cap_mark, tb_prev;
  logic [CODE_W-1:0] cap_code;
  logic              cyc_ok;

  always_comb begin
    logic found;
    logic [CYC_W-1:0] msk;
    found  = 1'b0;
    cyc_ok = 1'b1;
    for (int k = CYC_W; k >= 1; k--) begin
      msk = CYC_W'((1 << k) - 1);
      if (!found && cap_code[k]) begin
        found  = 1'b1;
        cyc_ok = ((cycle_cnt ^ cap_code[CYC_W-1:0]) & msk) == '0;
      end
    end
  end

  always_ff @(posedge clk_c or negedge rst_c_n) begin
    if (!rst_c_n) begin
      rq1      <= 1'b0;
      rq2      <= 1'b0;
      rq3      <= 1'b0;
      cap_mark <= '0;
      cap_code <= '0;
      tb_prev  <= '0;
      match    <= 1'b0;
    end else begin
      rq1 <= req_t;
      rq2 <= rq1;
      rq3 <= rq2;
      if (rq2 ^ rq3) begin
        cap_mark <= mark_q;
        cap_code <= code_q;
      end
      tb_prev <= time_base;
      match   <= (time_base != tb_prev) && (time_base == cap_mark) && cyc_ok;
    end
  end
endmodule

// File: rtl/ttmark_matcher_chk.sv
module ttmark_matcher_chk (
  input logic        clk_h,
  input logic        rst_h_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] rd_data,
  input logic        clk_c,
  input logic        rst_c_n,
  input logic [15:0] time_base,
  input logic        match,
  input logic [15:0] cap_mark
);
  p_resv_zero_r2: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    rd_data[30:23] == 8'h00);

  p_locked_write_r3: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (wr_en && !wr_sel && rd_data[31]) |=> rd_data[22:0] == $past(rd_data[22:0]));

  p_cfg_lock_r4: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (wr_en && wr_sel) |=> rd_data[31]);

  p_mark_equal_r7: assert property (@(posedge clk_c) disable iff (!rst_c_n)
    match |-> $past(time_base) == $past(cap_mark));

  p_no_repeat_r8: assert property (@(posedge clk_c) disable iff (!rst_c_n)
    (match && $past(match)) |-> $past(time_base) != $past(time_base, 2));
endmodule

bind ttmark_matcher ttmark_matcher_chk u_chk (
  .clk_h(clk_h), .rst_h_n(rst_h_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_data(rd_data), .clk_c(clk_c), .rst_c_n(rst_c_n),
  .time_base(time_base), .match(match), .cap_mark(cap_mark));

// File: tb/tb_ttmark_matcher.sv
module tb_ttmark_matcher;
  logic        clk_h = 0, clk_c = 0;
  logic        rst_h_n = 0, rst_c_n = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [15:0] time_base = 0;
  logic [5:0]  cycle_cnt = 0;
  logic        match;

  int checks = 0, errors = 0;
  logic [15:0] m_mark = 0, m_prev = 0;
  logic [6:0]  m_code = 0;

  always #5 clk_h = ~clk_h;
  always #7 clk_c = ~clk_c;

  ttmark_matcher dut (.*);

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk_h);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(logic [6:0] c, logic [5:0] y);
    int k = 6;
    while (k > 0 && !c[k]) k--;
    if (k == 0) return 1'b1;
    return (int'(y) % (1 << k)) == (int'(c) % (1 << k));
  endfunction

  task automatic hwrite(bit sel, logic [31:0] d);
    @(negedge clk_h);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk_h);
    wr_en = 0;
  endtask

  task automatic wait_unlock(string req);
    int n = 0;
    while (rd_data[31] && n < 100) begin
      @(negedge clk_h);
      n++;
    end
    chk(n <= 16, req, n, 16);
  endtask

  task automatic step(logic [15:0] tb, logic [5:0] cy, string req);
    bit e;
    @(negedge clk_c);
    time_base = tb; cycle_cnt = cy;
    e = (tb != m_prev) && (tb == m_mark) && exp_ok(m_code, cy);
    m_prev = tb;
    @(negedge clk_c);
    chk(match == e, req, match, e);
  endtask

  task automatic set_mark(logic [15:0] mk, logic [6:0] cd);
    hwrite(1, 32'h1);
    wait_unlock("R6");
    hwrite(0, {9'b0, cd, mk});
    chk(rd_data[31] == 1'b1, "R5", rd_data[31], 1);
    wait_unlock("R6");
    m_mark = mk; m_code = cd;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_h);
    chk(rd_data == 0 && match == 0, "R1", {rd_data[30:0], match}, 0);
    rst_h_n = 1; rst_c_n = 1;
    repeat (2) @(negedge clk_h);
    chk(rd_data == 0, "R1", rd_data, 0);

    hwrite(0, 32'hFFFF_FFFF);
    chk(rd_data == 32'h007F_FFFF, "R2", rd_data, 32'h007F_FFFF);
    repeat (3) @(negedge clk_h);
    chk(rd_data[31] == 0, "R5", rd_data[31], 0);

    hwrite(1, 32'h0);
    chk(rd_data[31] == 1, "R4", rd_data[31], 1);
    hwrite(0, 32'h0012_3456);
    chk(rd_data[22:0] == 23'h7F_FFFF, "R3", rd_data[22:0], 23'h7F_FFFF);
    wait_unlock("R6");
    m_mark = 16'hFFFF; m_code = 7'h7F;

    hwrite(1, 32'h2);
    wait_unlock("R6");
    hwrite(0, 32'hFF2B_0010);
    chk(rd_data == 32'h802B_0010, "R3", rd_data, 32'h802B_0010);
    wait_unlock("R6");
    m_mark = 16'h0010; m_code = 7'h2B;

    step(16'h0010, 6'd11, "R7");
    step(16'h0010, 6'd11, "R8");
    step(16'h0005, 6'd43, "R7");
    step(16'h0010, 6'd43, "R10");
    step(16'h0005, 6'd12, "R10");
    step(16'h0010, 6'd12, "R10");

    set_mark(16'h0100, 7'h01);
    for (int i = 0; i < 6; i++) begin
      step(16'h0003, 6'(i * 11), "R9");
      step(16'h0100, 6'(i * 11), "R9");
    end

    set_mark(16'h0100, 7'h40);
    step(16'h0003, 6'd0, "R10");
    step(16'h0100, 6'd1, "R10");
    step(16'h0003, 6'd0, "R10");
    step(16'h0100, 6'd0, "R10");

    hwrite(1, 32'h0);
    wait_unlock("R6");
    hwrite(0, {9'b0, 7'h00, 16'h0200});
    chk(rd_data[31] == 0, "R5", rd_data[31], 0);
    step(16'h0005, 6'd2, "R11");
    step(16'h0200, 6'd2, "R11");
    step(16'h0100, 6'd0, "R11");
    hwrite(1, 32'h1);
    wait_unlock("R6");
    m_mark = 16'h0200; m_code = 7'h00;
    step(16'h0005, 6'd3, "R11");
    step(16'h0200, 6'd3, "R11");

    for (int r = 0; r < 10; r++) begin
      logic [15:0] mk;
      logic [6:0]  cd;
      mk = 16'($urandom());
      cd = 7'($urandom());
      set_mark(mk, cd);
      for (int s = 0; s < 40; s++) begin
        logic [15:0] tb;
        case ($urandom_range(0, 2))
          0: tb = mk;
          1: tb = mk + 16'd1;
          default: tb = mk - 16'd1;
        endcase
        step(tb, 6'($urandom()), (cd[6:1] == 0) ? "R9" : "R10");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule